// File: doc/BRIEF.md
# Programmable YCbCr-to-RGB Color Matrix

This block converts a stream of pixels for a single display plane from YCbCr to RGB. Each pixel has three 10-bit components: luma unsigned (0..1023) and the two chroma components as signed two's complement values centred on zero. A programmable 3x3 signed matrix turns them into 10-bit RGB. Every input component is first limited to its own programmable window and then shifted by its own programmable offset. After the multiply, the three row sums are rounded and offset, and each is limited to its own output window. For limited-range luma, for example, the input window is 64..940 with an offset of -64.

Software programs the coefficients, offsets and limits through a simple write port into a staging copy. A frame-start strobe copies the staged settings into the working set and latches whether the coming frame is YCbCr or RGB. Settings therefore change only between frames. In an RGB frame the matrix is skipped and pixels come out unchanged, with the same latency.

Top module: `ycc_rgb_matrix`

## Requirements
- R1: After reset, out_valid and all three outputs are 0. The working and staged settings hold: all coefficients 0, all offsets 0, input windows -1024..1023, output windows 0..1023, and RGB pass-through mode. A YCbCr frame started with no writes therefore outputs 0,0,0.
- R2: A pixel sampled with pix_valid high on rising edge n appears on the outputs after edge n+2, with out_valid high for exactly that one cycle. out_valid stays low after edge n+1.
- R3: In an RGB frame (frame_yuv low at frame start), out_r equals pix_cr, out_g equals pix_y and out_b equals pix_cb, bit for bit.
- R4: In a YCbCr frame, input columns are ordered (Cr, Y, Cb) with index c = 0,1,2, and rows give R, G, B with index r = 0,1,2. Coefficient Ck with k = 3r+c weights column c in row r, and 4096 represents 1.0.
- R5: Write address k (0..3) loads C(2k) from data bits 15:0 and C(2k+1) from bits 31:16. Address 4 loads C8 from bits 15:0.
- R6: Address 8+c sets the input window of column c (min in bits 10:0, max in bits 26:16, signed). The input is limited to this window first. Then the input offset at address 5+c (bits 10:0, signed) is added, before the multiply.
- R7: Address 11+r holds the output offset of row r, and address 14+r holds its output window (min bits 10:0, max bits 26:16). The offset is added after rounding, and the result is then limited to the window.
- R8: Each row sum is divided by 4096 and rounded to nearest, with exact halves going toward plus infinity (+0.5 goes to 1, -0.5 to 0, +1.5 to 2, -1.5 to -1).
- R9: Writes change only the staged copy. The working settings and the frame format change only on frame_start.
- R10: Writes to addresses 17..31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the staged settings |
| cfg_addr | input | 5 | Setting address |
| cfg_wdata | input | 32 | Write data |
| frame_start | input | 1 | Copies staged settings to working set, latches format |
| frame_yuv | input | 1 | At frame start: 1 = YCbCr frame, 0 = RGB pass-through |
| pix_valid | input | 1 | Input pixel strobe |
| pix_y | input | 10 | Luma (unsigned), or G in RGB frames |
| pix_cb | input | 10 | Blue-difference chroma (signed), or B in RGB frames |
| pix_cr | input | 10 | Red-difference chroma (signed), or R in RGB frames |
| out_valid | output | 1 | Output pixel strobe |
| out_r | output | 10 | Red |
| out_g | output | 10 | Green |
| out_b | output | 10 | Blue |

## Verification
The hardest behaviour to show from the ports is the staging. A register write on its own leaves no trace at the outputs. The stimulus therefore writes a full new matrix while an earlier all-zero YCbCr frame is still in force, pushes a pixel that must still come out as 0,0,0, and only then strobes frame start. Exact half-way rounding cases are also hard to reach with real colour matrices. They are reached with a frame whose only non-zero coefficients are +2048 and -2048 on luma, so that small odd luma values land on exact halves of both signs.

// File: rtl/ycc_rgb_matrix.sv
module ycc_rgb_matrix #(
  parameter int DW   = 10,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int AW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [2*CW-1:0]   cfg_wdata,
  input  logic              frame_start,
  input  logic              frame_yuv,
  input  logic              pix_valid,
  input  logic [DW-1:0]     pix_y,
  input  logic [DW-1:0]     pix_cb,
  input  logic [DW-1:0]     pix_cr,
  output logic              out_valid,
  output logic [DW-1:0]     out_r,
  output logic [DW-1:0]     out_g,
  output logic [DW-1:0]     out_b
);

  localparam int LW   = DW + 1;
  localparam int XW   = LW + 1;
  localparam int ACCW = XW + CW + 2;
  localparam int RW   = ACCW - FRAC;
  localparam int SW   = RW + 1;
  localparam int HALF = 1 << (FRAC - 1);
  localparam logic signed [LW-1:0] LMIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic signed [LW-1:0] LMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic signed [LW-1:0] OTOP = {1'b0, {DW{1'b1}}};

  logic signed [CW-1:0] coef_sh [9];
  logic signed [CW-1:0] coef_q  [9];
  logic signed [LW-1:0] ioff_sh [3], imin_sh [3], imax_sh [3];
  logic signed [LW-1:0] ooff_sh [3], omin_sh [3], omax_sh [3];
  logic signed [LW-1:0] ioff_q  [3], imin_q  [3], imax_q  [3];
  logic signed [LW-1:0] ooff_q  [3], omin_q  [3], omax_q  [3];
  logic                 fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 9; k++) coef_sh[k] <= '0;
      for (int c = 0; c < 3; c++) begin
        ioff_sh[c] <= '0;   imin_sh[c] <= LMIN; imax_sh[c] <= LMAX;
        ooff_sh[c] <= '0;   omin_sh[c] <= '0;   omax_sh[c] <= OTOP;
      end
    end else if (cfg_we) begin
      for (int k = 0; k < 4; k++)
        if (cfg_addr == AW'(k)) begin
          coef_sh[2*k]   <= cfg_wdata[CW-1:0];
          coef_sh[2*k+1] <= cfg_wdata[2*CW-1:CW];
        end
      if (cfg_addr == AW'(4)) coef_sh[8] <= cfg_wdata[CW-1:0];
      for (int c = 0; c < 3; c++) begin
        if (cfg_addr == AW'(5 + c)) ioff_sh[c] <= cfg_wdata[LW-1:0];
        if (cfg_addr == AW'(8 + c)) begin
          imin_sh[c] <= cfg_wdata[LW-1:0];
          imax_sh[c] <= cfg_wdata[CW+LW-1:CW];
        end
        if (cfg_addr == AW'(11 + c)) ooff_sh[c] <= cfg_wdata[LW-1:0];
        if (cfg_addr == AW'(14 + c)) begin
          omin_sh[c] <= cfg_wdata[LW-1:0];
          omax_sh[c] <= cfg_wdata[CW+LW-1:CW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= 1'b0;
      for (int k = 0; k < 9; k++) coef_q[k] <= '0;
      for (int c = 0; c < 3; c++) begin
        ioff_q[c] <= '0;   imin_q[c] <= LMIN; imax_q[c] <= LMAX;
        ooff_q[c] <= '0;   omin_q[c] <= '0;   omax_q[c] <= OTOP;
      end
    end else if (frame_start) begin
      fmt_q <= frame_yuv;
      for (int k = 0; k < 9; k++) coef_q[k] <= coef_sh[k];
      for (int c = 0; c < 3; c++) begin
        ioff_q[c] <= ioff_sh[c]; imin_q[c] <= imin_sh[c]; imax_q[c] <= imax_sh[c];
        ooff_q[c] <= ooff_sh[c]; omin_q[c] <= omin_sh[c]; omax_q[c] <= omax_sh[c];
      end
    end
  end

  logic signed [LW-1:0]   xin [3], xcl [3];
  logic        [DW-1:0]   raw [3];
  logic signed [XW-1:0]   s1_x [3];
  logic        [DW-1:0]   s1_raw [3], s2_raw [3];
  logic                   s1_v, s2_v, s1_byp, s2_byp, out_byp;
  logic signed [ACCW-1:0] acc_c [3], s2_acc [3], biased [3];
  logic signed [RW-1:0]   rq [3];
  logic signed [SW-1:0]   sum [3], lim [3];
  logic        [DW-1:0]   q [3];

  assign xin[0] = {pix_cr[DW-1], pix_cr};
  assign xin[1] = {1'b0, pix_y};
  assign xin[2] = {pix_cb[DW-1], pix_cb};
  assign raw[0] = pix_cr;
  assign raw[1] = pix_y;
  assign raw[2] = pix_cb;

  always_comb
    for (int c = 0; c < 3; c++)
      xcl[c] = (xin[c] < imin_q[c]) ? imin_q[c] :
               (xin[c] > imax_q[c]) ? imax_q[c] : xin[c];

  always_comb
    for (int r = 0; r < 3; r++)
      acc_c[r] = ACCW'(s1_x[0]) * ACCW'(coef_q[3*r])
               + ACCW'(s1_x[1]) * ACCW'(coef_q[3*r+1])
               + ACCW'(s1_x[2]) * ACCW'(coef_q[3*r+2]);

  always_comb
    for (int r = 0; r < 3; r++) begin
      biased[r] = s2_acc[r] + ACCW'(HALF);
      rq[r]     = $signed(biased[r][ACCW-1:FRAC]);
      sum[r]    = SW'(rq[r]) + SW'(ooff_q[r]);
      lim[r]    = (sum[r] < SW'(omin_q[r])) ? SW'(omin_q[r]) :
                  (sum[r] > SW'(omax_q[r])) ? SW'(omax_q[r]) : sum[r];
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; out_valid <= 1'b0;
      s1_byp <= 1'b0; s2_byp <= 1'b0; out_byp <= 1'b0;
      for (int c = 0; c < 3; c++) begin
        s1_x[c] <= '0; s1_raw[c] <= '0; s2_raw[c] <= '0;
        s2_acc[c] <= '0; q[c] <= '0;
      end
    end else begin
      s1_v <= pix_valid;  s2_v <= s1_v;  out_valid <= s2_v;
      s1_byp <= !fmt_q;   s2_byp <= s1_byp; out_byp <= s2_byp;
      for (int c = 0; c < 3; c++) begin
        s1_x[c]   <= XW'(xcl[c]) + XW'(ioff_q[c]);
        s1_raw[c] <= raw[c];
        s2_raw[c] <= s1_raw[c];
        s2_acc[c] <= acc_c[c];
        q[c]      <= s2_byp ? s2_raw[c] : lim[c][DW-1:0];
      end
    end
  end

  assign out_r = q[0];
  assign out_g = q[1];
  assign out_b = q[2];

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##3 out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> ##3 !out_valid);
  a_r3_bypass_r: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_byp) |-> (out_r == $past(pix_cr, 3)));
  a_r7_out_clamp_r: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_byp && omin_q[0] <= omax_q[0]) |->
      ($signed({1'b0, out_r}) >= omin_q[0] && $signed({1'b0, out_r}) <= omax_q[0]));
  a_r9_hold_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fmt_q));
  a_r9_hold_coef: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(coef_q[1]));

endmodule

// File: tb/ycc_rgb_matrix_tb_top.sv
module ycc_rgb_matrix_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, frame_start = 1'b0, frame_yuv = 1'b0, pix_valid = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [9:0]  pix_y = '0, pix_cb = '0, pix_cr = '0;
  logic        out_valid;
  logic [9:0]  out_r, out_g, out_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  ycc_rgb_matrix dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .frame_yuv(frame_yuv),
    .pix_valid(pix_valid), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  // y, cb, cr, expected r, g, b under full-range settings
  localparam int VEC [5][6] = '{
    '{512,    0,    0,  512,  512,  512},
    '{  0,    0,  100,  140,    0,    0},
    '{1023, 511,  511, 1023,  482, 1023},
    '{300, -100,  -50,  230,  370,  123},
    '{  0, -512, -512,    0,  542,    0}};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] pack(int hi, int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  task automatic frame(bit yuv);
    @(negedge clk); frame_start = 1'b1; frame_yuv = yuv;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic push(string tag, int y, int cb, int cr, int er, int eg, int eb);
    @(negedge clk); pix_y = 10'(y); pix_cb = 10'(cb); pix_cr = 10'(cr); pix_valid = 1'b1;
    @(negedge clk); pix_valid = 1'b0;
    @(negedge clk); chk({tag, " R2 early valid"}, int'(out_valid), 0);
    @(negedge clk);
    chk({tag, " R2 valid"}, int'(out_valid), 1);
    chk({tag, " r"}, int'(out_r), er);
    chk({tag, " g"}, int'(out_g), eg);
    chk({tag, " b"}, int'(out_b), eb);
    @(negedge clk); chk({tag, " R2 one-shot"}, int'(out_valid), 0);
  endtask

  task automatic load_full();
    wr(0, pack(4096, 5743)); wr(1, pack(-2925, 0)); wr(2, pack(-1410, 4096));
    wr(3, pack(4096, 0));    wr(4, pack(0, 7258));
    for (int c = 0; c < 3; c++) wr(5 + c, 0);
    wr(8, pack(512, -512)); wr(9, pack(1023, 0)); wr(10, pack(512, -512));
    for (int r = 0; r < 3; r++) begin wr(11 + r, 0); wr(14 + r, pack(1023, 0)); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset r", int'(out_r), 0);
    chk("R1 reset g", int'(out_g), 0);
    chk("R1 reset b", int'(out_b), 0);
    rst_n = 1'b1;

    push("R1 R3 default bypass", 5, 6, 7, 7, 5, 6);
    frame(1'b1);
    push("R1 zero matrix", 500, 10, 20, 0, 0, 0);

    load_full();
    push("R9 staged only", 500, 10, 20, 0, 0, 0);
    frame(1'b1);
    for (int i = 0; i < 5; i++)
      push("R4 R5 table", VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);

    frame(1'b0);
    push("R3 rgb frame", 100, 1023, 1023, 1023, 100, 1023);

    wr(0, pack(4769, 6537)); wr(1, pack(-3330, 0)); wr(2, pack(-1605, 4769));
    wr(3, pack(4769, 0));    wr(4, pack(0, 8263));
    wr(6, pack(0, -64));
    wr(8, pack(448, -448)); wr(9, pack(940, 64)); wr(10, pack(448, -448));
    wr(15, pack(600, 100));
    frame(1'b1);
    push("R6 R7 luma max", 1023, 0, 0, 1020, 600, 1020);
    push("R6 R7 chroma max", 64, 0, 511, 715, 100, 0);
    push("R6 luma min", 0, 0, 0, 0, 100, 0);

    for (int k = 0; k < 5; k++) wr(k, 0);
    wr(0, pack(2048, 0)); wr(2, pack(0, -2048));
    wr(6, 0); wr(9, pack(1023, 0));
    wr(12, 10); wr(15, pack(1023, 0));
    frame(1'b1);
    push("R8 half", 1, 0, 0, 1, 10, 0);
    push("R8 one and half", 3, 0, 0, 2, 9, 0);

    wr(20, 32'hFFFF_FFFF); wr(31, 32'h8000_8000); wr(17, 32'h7FFF_7FFF);
    frame(1'b1);
    push("R10 unmapped", 3, 0, 0, 2, 9, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule